// File: doc/BRIEF.md
# Window Scaler DDA Stepper

The stepper maps output pixel positions of a display window back to source
image coordinates. A source image of width W and height H is stretched or
shrunk onto an output area of width OW and height OH. Each axis uses a
fixed-point digital differential analyser (DDA) with 12 fractional bits.
The per-axis increment is the source size scaled by 4096 and divided by one
less than the output size. The divisor is never allowed below 1.

Software or a sequencer presents the geometry and a pixel-depth code, then
pulses `load`. A sequential divider computes both increments together, and
`ready` rises when they are valid. The pixel pipeline then drives
`frame_start` once per frame, and `pix_adv` once per output pixel. It
qualifies the last pixel of each output line with `line_end`. The block
returns the integer source column and row, and the byte offset of that
source pixel inside a packed frame buffer.

Top module: `win_dda_stepper`

## Requirements
- R1: After reset, `ready` and `fmt_err` are 0 and `src_x`, `src_y` and `byte_ofs` are 0.
- R2: A load with `depth_log2` = 4 selects 16-bit pixels: `line_bytes` = W*2 and `color_expand` = 1. A load with `depth_log2` = 5 selects 32-bit pixels: `line_bytes` = W*4 and `color_expand` = 0.
- R3: A load with any other `depth_log2` sets `fmt_err` to 1 and leaves `ready` at 0 until the next load with a legal code. That legal load clears `fmt_err`.
- R4: `ready` is 0 in the cycle after a load and rises no later than 24 cycles after the load edge. From then on, `h_inc` = floor(W*4096 / max(OW-1,1)) and `v_inc` = floor(H*4096 / max(OH-1,1)). An OW or OH of 0 or 1 uses a divisor of 1.
- R5: A load zeroes both accumulators. A `frame_start` seen while `ready` is 1 also zeroes both accumulators, and it takes priority over a `pix_adv` in the same cycle.
- R6: `pix_adv` without `line_end` adds `h_inc` to the horizontal accumulator. `src_x` is the accumulator shifted right by 12, clamped to W-1.
- R7: `pix_adv` with `line_end` clears the horizontal accumulator and adds `v_inc` to the vertical accumulator. `src_y` is the vertical accumulator shifted right by 12, clamped to H-1.
- R8: `byte_ofs` = `src_y`*`line_bytes` + `src_x`*bytes-per-pixel, where bytes-per-pixel is 2 or 4.
- R9: While `ready` is 0, `frame_start` and `pix_adv` have no effect. The accumulators keep their values.
- R10: Each accumulator is 25 bits wide, with 12 integer bits plus 1 guard bit above the 12 fractional bits. It saturates at all ones rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Latch geometry and start the increment division |
| src_w | input | 12 | Source width W in pixels |
| src_h | input | 12 | Source height H in lines |
| dst_w | input | 12 | Output width OW |
| dst_h | input | 12 | Output height OH |
| depth_log2 | input | 3 | Pixel depth code: 4 means 16-bit, 5 means 32-bit |
| frame_start | input | 1 | Restart both accumulators |
| pix_adv | input | 1 | Advance by one output pixel |
| line_end | input | 1 | Qualifies `pix_adv` as the last pixel of a line |
| ready | output | 1 | Increments valid and stepping enabled |
| fmt_err | output | 1 | Last load had an unsupported depth code |
| color_expand | output | 1 | Pixel depth is below 24 bits |
| line_bytes | output | 14 | Source line size and stride in bytes |
| h_inc | output | 24 | Horizontal increment, 12 fractional bits |
| v_inc | output | 24 | Vertical increment, 12 fractional bits |
| src_x | output | 12 | Integer source column |
| src_y | output | 12 | Integer source row |
| byte_ofs | output | 26 | Byte offset of the source pixel |

## Verification
Frame restart and pixel advance can both arrive in the same cycle. The bench
provokes this on a window whose accumulators are already away from zero. It
then judges that both coordinates and the byte offset read zero on the next
cycle, which shows the restart won. The bench also drives pixel advances
while the divider is still busy, and expects coordinate zero once `ready`
rises.

// File: rtl/win_dda_stepper.sv
module win_dda_stepper #(
  parameter int DIM_W = 12,
  parameter int FRAC  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [DIM_W-1:0]         src_w,
  input  logic [DIM_W-1:0]         src_h,
  input  logic [DIM_W-1:0]         dst_w,
  input  logic [DIM_W-1:0]         dst_h,
  input  logic [2:0]               depth_log2,
  input  logic                     frame_start,
  input  logic                     pix_adv,
  input  logic                     line_end,
  output logic                     ready,
  output logic                     fmt_err,
  output logic                     color_expand,
  output logic [DIM_W+1:0]         line_bytes,
  output logic [DIM_W+FRAC-1:0]    h_inc,
  output logic [DIM_W+FRAC-1:0]    v_inc,
  output logic [DIM_W-1:0]         src_x,
  output logic [DIM_W-1:0]         src_y,
  output logic [2*DIM_W+1:0]       byte_ofs
);
  localparam int NUM_W = DIM_W + FRAC;
  localparam int ACC_W = NUM_W + 1;
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int OFS_W = 2 * DIM_W + 2;
  localparam logic [2:0] DEPTH16 = 3'd4;
  localparam logic [2:0] DEPTH32 = 3'd5;

  logic [DIM_W-1:0] w_r, h_r, hdiv_r, vdiv_r;
  logic             wide_r, busy;
  logic [CNT_W-1:0] cnt;
  logic [DIM_W:0]   hrem, vrem;
  logic [NUM_W-1:0] hq, vq;
  logic [ACC_W-1:0] hacc, vacc;

  logic [DIM_W-1:0] hdiv_in, vdiv_in;
  logic             depth_ok;
  assign hdiv_in  = (dst_w > DIM_W'(1)) ? dst_w - DIM_W'(1) : DIM_W'(1);
  assign vdiv_in  = (dst_h > DIM_W'(1)) ? dst_h - DIM_W'(1) : DIM_W'(1);
  assign depth_ok = (depth_log2 == DEPTH16) || (depth_log2 == DEPTH32);

  // one restoring-division step: shift remainder left, subtract if it fits
  function automatic logic [DIM_W+NUM_W:0] div_step(
    input logic [DIM_W:0]   rem,
    input logic [NUM_W-1:0] quo,
    input logic [DIM_W-1:0] dvs
  );
    logic [DIM_W:0] t;
    t = {rem[DIM_W-1:0], quo[NUM_W-1]};
    if (t >= {1'b0, dvs})
      return {t - {1'b0, dvs}, quo[NUM_W-2:0], 1'b1};
    else
      return {t, quo[NUM_W-2:0], 1'b0};
  endfunction

  logic [DIM_W+NUM_W:0] hnext, vnext;
  assign hnext = div_step(hrem, hq, hdiv_r);
  assign vnext = div_step(vrem, vq, vdiv_r);

  logic [ACC_W:0]   hsum_full, vsum_full;
  logic [ACC_W-1:0] hsum, vsum;
  assign hsum_full = {1'b0, hacc} + (ACC_W+1)'(hq);
  assign vsum_full = {1'b0, vacc} + (ACC_W+1)'(vq);
  assign hsum = hsum_full[ACC_W] ? '1 : hsum_full[ACC_W-1:0];
  assign vsum = vsum_full[ACC_W] ? '1 : vsum_full[ACC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_r <= '0; h_r <= '0; hdiv_r <= DIM_W'(1); vdiv_r <= DIM_W'(1);
      wide_r <= 1'b0; busy <= 1'b0; ready <= 1'b0; fmt_err <= 1'b0;
      cnt <= '0; hrem <= '0; vrem <= '0; hq <= '0; vq <= '0;
      hacc <= '0; vacc <= '0;
    end else if (load) begin
      w_r    <= src_w;
      h_r    <= src_h;
      hdiv_r <= hdiv_in;
      vdiv_r <= vdiv_in;
      wide_r <= (depth_log2 == DEPTH32);
      hrem   <= '0;
      vrem   <= '0;
      hq     <= {src_w, {FRAC{1'b0}}};
      vq     <= {src_h, {FRAC{1'b0}}};
      cnt    <= '0;
      hacc   <= '0;
      vacc   <= '0;
      ready  <= 1'b0;
      busy   <= depth_ok;
      fmt_err <= !depth_ok;
    end else if (busy) begin
      {hrem, hq} <= hnext;
      {vrem, vq} <= vnext;
      cnt <= cnt + CNT_W'(1);
      if (cnt == CNT_W'(NUM_W - 1)) begin
        busy  <= 1'b0;
        ready <= 1'b1;
      end
    end else if (ready) begin
      if (frame_start) begin
        hacc <= '0;
        vacc <= '0;
      end else if (pix_adv) begin
        if (line_end) begin
          hacc <= '0;
          vacc <= vsum;
        end else begin
          hacc <= hsum;
        end
      end
    end
  end

  logic [DIM_W:0]   xi, yi;
  logic [DIM_W-1:0] xlim, ylim;
  assign xi   = hacc[ACC_W-1:FRAC];
  assign yi   = vacc[ACC_W-1:FRAC];
  assign xlim = (w_r == '0) ? '0 : w_r - DIM_W'(1);
  assign ylim = (h_r == '0) ? '0 : h_r - DIM_W'(1);
  assign src_x = ({1'b0, xlim} < xi) ? xlim : xi[DIM_W-1:0];
  assign src_y = ({1'b0, ylim} < yi) ? ylim : yi[DIM_W-1:0];

  assign h_inc        = hq;
  assign v_inc        = vq;
  assign color_expand = !wide_r;
  assign line_bytes   = wide_r ? {w_r, 2'b00} : {1'b0, w_r, 1'b0};
  assign byte_ofs     = OFS_W'(src_y) * OFS_W'(line_bytes)
                      + (OFS_W'(src_x) << (wide_r ? 2 : 1));

  // R4
  load_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ready);

  // R3
  bad_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> !ready);

  // R5
  sof_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !load && frame_start) |=> (src_x == '0 && src_y == '0));

  // R7
  eol_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !load && !frame_start && pix_adv && line_end)
      |=> (src_x == '0 && vacc >= $past(vacc)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !load) |=> ($stable(hacc) && $stable(vacc)));

  // R10
  sat_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !load && !frame_start && pix_adv && !line_end)
      |=> hacc >= $past(hacc));

  // R6
  clamp_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_x <= xlim);
endmodule

// File: tb/test_win_dda_stepper.sv
`timescale 1ns/1ps
module test_win_dda_stepper;
  localparam int DIM_W = 12;
  localparam int FRAC  = 12;
  localparam longint ACC_MAX = (64'd1 << 25) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [DIM_W-1:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
  logic [2:0] depth_log2 = '0;
  logic frame_start = 1'b0, pix_adv = 1'b0, line_end = 1'b0;
  logic ready, fmt_err, color_expand;
  logic [DIM_W+1:0] line_bytes;
  logic [DIM_W+FRAC-1:0] h_inc, v_inc;
  logic [DIM_W-1:0] src_x, src_y;
  logic [2*DIM_W+1:0] byte_ofs;

  always #2.5 clk = ~clk;

  win_dda_stepper #(.DIM_W(DIM_W), .FRAC(FRAC)) i_win_dda_stepper (
    .clk(clk), .rst_n(rst_n), .load(load),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
    .depth_log2(depth_log2), .frame_start(frame_start),
    .pix_adv(pix_adv), .line_end(line_end),
    .ready(ready), .fmt_err(fmt_err), .color_expand(color_expand),
    .line_bytes(line_bytes), .h_inc(h_inc), .v_inc(v_inc),
    .src_x(src_x), .src_y(src_y), .byte_ofs(byte_ofs));

  int tests = 0, fails = 0;
  bit done = 0;
  longint m_w, m_h, m_hinc, m_vinc, m_hacc, m_vacc;
  bit m_wide, m_rdy;

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint sat(longint v);
    return (v > ACC_MAX) ? ACC_MAX : v;
  endfunction

  function automatic longint exp_x();
    longint lim = (m_w == 0) ? 0 : m_w - 1;
    longint xi = m_hacc >> 12;
    return (xi > lim) ? lim : xi;
  endfunction

  function automatic longint exp_y();
    longint lim = (m_h == 0) ? 0 : m_h - 1;
    longint yi = m_vacc >> 12;
    return (yi > lim) ? lim : yi;
  endfunction

  task automatic check_pos(string tag);
    longint bpp = m_wide ? 4 : 2;
    check({tag, " R6 src_x"}, longint'(src_x), exp_x());
    check({tag, " R7 src_y"}, longint'(src_y), exp_y());
    check({tag, " R8 byte_ofs"}, longint'(byte_ofs),
          exp_y() * m_w * bpp + exp_x() * bpp);
  endtask

  function automatic void model_edge(bit s, bit a, bit e);
    if (!m_rdy) return;
    if (s) begin m_hacc = 0; m_vacc = 0; end
    else if (a) begin
      if (e) begin m_hacc = 0; m_vacc = sat(m_vacc + m_vinc); end
      else m_hacc = sat(m_hacc + m_hinc);
    end
  endfunction

  task automatic step(bit s, bit a, bit e);
    @(negedge clk);
    frame_start = s; pix_adv = a; line_end = e;
    @(negedge clk);
    frame_start = 0; pix_adv = 0; line_end = 0;
    model_edge(s, a, e);
  endtask

  task automatic load_geom(int w, int h, int ow, int oh, int dep, bit poke);
    bit legal = (dep == 4) || (dep == 5);
    int waited = 0;
    @(negedge clk);
    src_w = w[DIM_W-1:0]; src_h = h[DIM_W-1:0];
    dst_w = ow[DIM_W-1:0]; dst_h = oh[DIM_W-1:0];
    depth_log2 = dep[2:0]; load = 1;
    @(negedge clk);
    load = 0;
    m_rdy = 0; m_hacc = 0; m_vacc = 0;
    check("R4 ready low after load", longint'(ready), 0);
    if (poke) begin pix_adv = 1; frame_start = 0; end
    if (legal) begin
      while (!ready && waited < 30) begin
        @(negedge clk);
        waited++;
        if (waited == 5) pix_adv = 0;
      end
      pix_adv = 0;
      check("R4 ready within bound", longint'(waited <= 24 && ready), 1);
      m_rdy = 1; m_w = w; m_h = h; m_wide = (dep == 5);
      m_hinc = (longint'(w) * 4096) / ((ow > 1) ? ow - 1 : 1);
      m_vinc = (longint'(h) * 4096) / ((oh > 1) ? oh - 1 : 1);
      check("R4 h_inc", longint'(h_inc), m_hinc);
      check("R4 v_inc", longint'(v_inc), m_vinc);
      check("R2 line_bytes", longint'(line_bytes), longint'(w) * (m_wide ? 4 : 2));
      check("R2 color_expand", longint'(color_expand), m_wide ? 0 : 1);
      check("R3 fmt_err clear", longint'(fmt_err), 0);
    end else begin
      repeat (30) @(negedge clk);
      pix_adv = 0;
      check("R3 fmt_err set", longint'(fmt_err), 1);
      check("R3 ready stays low", longint'(ready), 0);
    end
  endtask

  task automatic t_reset();
    check("R1 ready", longint'(ready), 0);
    check("R1 fmt_err", longint'(fmt_err), 0);
    check("R1 src_x", longint'(src_x), 0);
    check("R1 src_y", longint'(src_y), 0);
    check("R1 byte_ofs", longint'(byte_ofs), 0);
  endtask

  task automatic t_upscale16();
    load_geom(320, 240, 640, 480, 4, 0);
    for (int i = 0; i < 12; i++) begin
      step(0, 1, 0);
      check_pos("upscale step");
    end
    step(0, 1, 1);
    check_pos("R7 line end");
    for (int i = 0; i < 645; i++) step(0, 1, 0);
    check_pos("R6 clamp at right edge");
    check("R6 clamp value", longint'(src_x), 319);
  endtask

  task automatic t_down32();
    load_geom(100, 50, 10, 5, 5, 0);
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 4; i++) begin
        step(0, 1, 0);
        check_pos("down32 pixel");
      end
      step(0, 1, 1);
      check_pos("R7 down32 row");
    end
    check("R7 clamp y", longint'(src_y), 49);
  endtask

  task automatic t_sof_collide();
    load_geom(64, 64, 32, 32, 4, 0);
    step(0, 1, 0); step(0, 1, 0); step(0, 1, 1); step(0, 1, 0);
    check_pos("pre collide");
    step(1, 1, 0);
    check("R5 sof wins x", longint'(src_x), 0);
    check("R5 sof wins y", longint'(src_y), 0);
    check("R5 sof wins ofs", longint'(byte_ofs), 0);
  endtask

  task automatic t_bad_fmt();
    load_geom(64, 64, 32, 32, 3, 1);
    step(0, 1, 0);
    check("R9 ignored x", longint'(src_x), 0);
    check("R3 still not ready", longint'(ready), 0);
    load_geom(64, 64, 32, 32, 5, 0);
    step(0, 1, 0);
    check_pos("R3 recovered");
  endtask

  task automatic t_busy_ignore();
    load_geom(200, 100, 50, 25, 4, 1);
    check("R9 busy pix ignored x", longint'(src_x), 0);
    check("R9 busy pix ignored y", longint'(src_y), 0);
    step(0, 1, 0);
    check_pos("R9 after ready");
  endtask

  task automatic t_saturate();
    load_geom(2048, 2048, 1, 0, 4, 0);
    check("R4 floor divisor h", longint'(h_inc), 2048 * 4096);
    @(negedge clk);
    pix_adv = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      model_edge(0, 1, 0);
    end
    pix_adv = 0;
    check("R10 saturated x", longint'(src_x), 2047);
    check_pos("R10 saturation");
    step(0, 1, 1); step(0, 1, 1); step(0, 1, 1); step(0, 1, 1); step(0, 1, 1);
    check("R10 saturated y", longint'(src_y), 2047);
    check_pos("R10 saturation y");
  endtask

  initial begin
    m_rdy = 0; m_hacc = 0; m_vacc = 0; m_w = 0; m_h = 0; m_wide = 0;
    m_hinc = 0; m_vinc = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_upscale16();
    t_down32();
    t_sof_collide();
    t_bad_fmt();
    t_busy_ignore();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule